// File: doc/BRIEF.md
# Spindle Servo Mode Sequencer

This block chooses the working mode of a constant-linear-velocity spindle servo. Under the normal command it moves by itself between speed control, used while the disc is spinning up or has lost frame lock, and phase control, used once frame lock is present. The lock flag is looked at only on a slow sampling tick. One locked sample is enough to enter phase control. Dropping back to speed control needs eight unlocked samples in a row.

Two other commands are available. The rough command gives a coarse mode that takes its reference from the VCO instead of the crystal. The stop command stops the motor: the drive pins are forced to their rest levels and the speed-error pin is released. The sequencer also steers which pair of counters the phase detector compares, and it passes the phase-error and speed-error levels from the detector to the motor-drive pins with the right output enables.

The four states are STOP, SPEED, PHASE and ROUGH. The transitions are as follows:
- STOP→SPEED on the normal command, and STOP→ROUGH on the rough command.
- SPEED→PHASE on a locked sample.
- PHASE→SPEED after the eighth consecutive unlocked sample.
- SPEED/PHASE→ROUGH on the rough command, and ROUGH→SPEED on the normal command.
- Any state→STOP on either stop encoding.

Top module: `spin_servo_seq`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) puts the block in STOP. `mode_o` encodes STOP=00, SPEED=01, PHASE=10, ROUGH=11.
- R2: In STOP the outputs are `pdrv_o`=0 with `pdrv_oe_o`=1, `fdrv_o`=0, `son_o`=0 and `sdrv_oe_o`=0 (pin released).
- R3: From STOP, `cmd_i`=00 (normal) gives SPEED on the next clock. Leaving STOP always starts with the unlock count at zero.
- R4: In SPEED under the normal command, a clock with `samp_tick_i`=1 and `lock_i`=1 gives PHASE on the next clock. `lock_i` has no effect on a clock without a tick.
- R5: In PHASE, the eighth consecutive tick with `lock_i`=0 gives SPEED on the next clock. Seven such ticks leave the block in PHASE.
- R6: A tick with `lock_i`=1 clears the consecutive-unlock count, so that after it eight new unlocked ticks are needed.
- R7: `cmd_i`=10 or 11 (stop) gives STOP on the next clock from any state.
- R8: `cmd_i`=01 (rough) gives ROUGH on the next clock from any state other than ROUGH. In ROUGH `vco_ref_o`=1 and ticks are ignored. In every other state `vco_ref_o`=0.
- R9: `cmp_sel_o` is 01 (frame clock against crystal) when `ref_sel_i`=0 and 10 (read counter against write counter) when `ref_sel_i`=1, in PHASE and ROUGH. It is 00 in STOP and SPEED.
- R10: In SPEED, `sdrv_oe_o`=1 with `sdrv_o`=`spd_err_i` and `pdrv_oe_o`=0. In PHASE and ROUGH, `pdrv_oe_o`=1 with `pdrv_o`=`ph_err_i` and `sdrv_oe_o`=0. In all three, `son_o`=1 and `fdrv_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmd_i | input | 2 | Mode command: 00 normal, 01 rough, 10/11 stop |
| ref_sel_i | input | 1 | Phase comparison pair select |
| samp_tick_i | input | 1 | One-cycle lock sampling strobe |
| lock_i | input | 1 | Frame lock flag |
| ph_err_i | input | 1 | Phase-error level from detector |
| spd_err_i | input | 1 | Speed-error level from detector |
| mode_o | output | 2 | Current mode |
| cmp_sel_o | output | 2 | Phase detector source pair |
| vco_ref_o | output | 1 | Reference taken from VCO |
| pdrv_o | output | 1 | Phase drive level |
| pdrv_oe_o | output | 1 | Phase drive enable |
| sdrv_o | output | 1 | Speed drive level |
| sdrv_oe_o | output | 1 | Speed drive enable |
| fdrv_o | output | 1 | Filter drive level |
| son_o | output | 1 | Motor on |

## Verification
The bench targets the unlock run boundary. After seven unlocked ticks the block must still be in PHASE, and after the eighth it must be in SPEED. An off-by-one counter would leave PHASE one tick early or one tick late. A locked tick placed inside a run checks that the count restarts, because a design that only pauses the count would drop out too soon. Stop is entered with a partial count already built up, so that a design that keeps the stale count after leaving STOP loses lock early. The bench also checks that lock changes without a tick are ignored, that ticks in ROUGH do nothing, and that the reserved command 11 stops the motor.

// File: rtl/spin_pkg.sv
package spin_pkg;

    typedef enum logic [1:0] {
        MD_STOP  = 2'b00,
        MD_SPEED = 2'b01,
        MD_PHASE = 2'b10,
        MD_ROUGH = 2'b11
    } spin_mode_t;

    typedef enum logic [1:0] {
        CMD_NORMAL = 2'b00,
        CMD_ROUGH  = 2'b01,
        CMD_STOP   = 2'b10,
        CMD_STOP_R = 2'b11
    } spin_cmd_t;

    localparam logic [1:0] CMP_NONE  = 2'b00;
    localparam logic [1:0] CMP_FRAME = 2'b01;
    localparam logic [1:0] CMP_RWCNT = 2'b10;

endpackage

// File: rtl/spin_lock_filter.sv
module spin_lock_filter #(
    parameter int UNLOCK_RUN = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic tick_i,
    input  logic lock_i,
    output logic seen_o,
    output logic lost_o
);
    localparam int CW = $clog2(UNLOCK_RUN + 1);
    localparam logic [CW-1:0] LAST = CW'(UNLOCK_RUN - 1);

    logic [CW-1:0] miss_q;

    // locked sample and final unlocked sample of a run
    assign seen_o = tick_i && lock_i;
    assign lost_o = en_i && tick_i && !lock_i && (miss_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i || seen_o || lost_o) begin
            miss_q <= '0;
        end else if (tick_i && !lock_i) begin
            miss_q <= miss_q + 1'b1;
        end
    end
endmodule

// File: rtl/spin_mode_fsm.sv
module spin_mode_fsm
    import spin_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] cmd_i,
    input  logic       seen_i,
    input  logic       lost_i,
    output spin_mode_t mode_o
);
    spin_mode_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cmd_i[1]) begin
            state_d = MD_STOP;
        end else begin
            unique case (state_q)
                MD_STOP:  state_d = (cmd_i == CMD_ROUGH) ? MD_ROUGH : MD_SPEED;
                MD_SPEED: if (cmd_i == CMD_ROUGH) state_d = MD_ROUGH;
                          else if (seen_i)        state_d = MD_PHASE;
                MD_PHASE: if (cmd_i == CMD_ROUGH) state_d = MD_ROUGH;
                          else if (lost_i)        state_d = MD_SPEED;
                MD_ROUGH: if (cmd_i == CMD_NORMAL) state_d = MD_SPEED;
                default:  state_d = MD_STOP;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= MD_STOP;
        else       state_q <= state_d;
    end

    assign mode_o = state_q;
endmodule

// File: rtl/spin_drive.sv
module spin_drive
    import spin_pkg::*;
(
    input  spin_mode_t mode_i,
    input  logic       ref_sel_i,
    input  logic       ph_err_i,
    input  logic       spd_err_i,
    output logic [1:0] cmp_sel_o,
    output logic       vco_ref_o,
    output logic       pdrv_o,
    output logic       pdrv_oe_o,
    output logic       sdrv_o,
    output logic       sdrv_oe_o,
    output logic       fdrv_o,
    output logic       son_o
);
    always_comb begin
        cmp_sel_o = CMP_NONE;
        vco_ref_o = 1'b0;
        pdrv_o    = 1'b0;
        pdrv_oe_o = 1'b1;
        sdrv_o    = 1'b0;
        sdrv_oe_o = 1'b0;
        fdrv_o    = 1'b0;
        son_o     = 1'b0;
        unique case (mode_i)
            MD_STOP: ;
            MD_SPEED: begin
                pdrv_oe_o = 1'b0;
                sdrv_o    = spd_err_i;
                sdrv_oe_o = 1'b1;
                fdrv_o    = 1'b1;
                son_o     = 1'b1;
            end
            MD_PHASE, MD_ROUGH: begin
                cmp_sel_o = ref_sel_i ? CMP_RWCNT : CMP_FRAME;
                vco_ref_o = (mode_i == MD_ROUGH);
                pdrv_o    = ph_err_i;
                fdrv_o    = 1'b1;
                son_o     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spin_servo_seq.sv
module spin_servo_seq
    import spin_pkg::*;
#(
    parameter int UNLOCK_RUN = 8
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] cmd_i,
    input  logic       ref_sel_i,
    input  logic       samp_tick_i,
    input  logic       lock_i,
    input  logic       ph_err_i,
    input  logic       spd_err_i,
    output logic [1:0] mode_o,
    output logic [1:0] cmp_sel_o,
    output logic       vco_ref_o,
    output logic       pdrv_o,
    output logic       pdrv_oe_o,
    output logic       sdrv_o,
    output logic       sdrv_oe_o,
    output logic       fdrv_o,
    output logic       son_o
);
    spin_mode_t mode;
    logic       seen, lost, track;

    // the unlock run only counts while phase control is running
    assign track = (mode == MD_PHASE) && (cmd_i == CMD_NORMAL);

    spin_lock_filter #(.UNLOCK_RUN(UNLOCK_RUN)) u_filt (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (track),
        .tick_i (samp_tick_i),
        .lock_i (lock_i),
        .seen_o (seen),
        .lost_o (lost)
    );

    spin_mode_fsm u_fsm (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cmd_i  (cmd_i),
        .seen_i (seen),
        .lost_i (lost),
        .mode_o (mode)
    );

    spin_drive u_drv (
        .mode_i    (mode),
        .ref_sel_i (ref_sel_i),
        .ph_err_i  (ph_err_i),
        .spd_err_i (spd_err_i),
        .cmp_sel_o (cmp_sel_o),
        .vco_ref_o (vco_ref_o),
        .pdrv_o    (pdrv_o),
        .pdrv_oe_o (pdrv_oe_o),
        .sdrv_o    (sdrv_o),
        .sdrv_oe_o (sdrv_oe_o),
        .fdrv_o    (fdrv_o),
        .son_o     (son_o)
    );

    assign mode_o = mode;
endmodule

// File: rtl/spin_servo_seq_chk.sv
module spin_servo_seq_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic [1:0] cmd_i,
    input logic       samp_tick_i,
    input logic       lock_i,
    input logic [1:0] mode_o,
    input logic [1:0] cmp_sel_o,
    input logic       vco_ref_o,
    input logic       pdrv_o,
    input logic       pdrv_oe_o,
    input logic       sdrv_oe_o,
    input logic       fdrv_o,
    input logic       son_o
);
    assert_reset_stop_R1: assert property (@(posedge clk_i)
        rst_i |=> mode_o == 2'b00);

    assert_stop_pins_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_o == 2'b00 |-> (!son_o && !fdrv_o && pdrv_oe_o && !pdrv_o && !sdrv_oe_o));

    assert_start_speed_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'b00 && cmd_i == 2'b00) |=> mode_o == 2'b01);

    assert_lock_entry_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'b10 && $past(mode_o) == 2'b01) |-> $past(samp_tick_i && lock_i));

    assert_unlock_exit_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'b01 && $past(mode_o) == 2'b10) |-> $past(samp_tick_i && !lock_i));

    assert_stop_cmd_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i[1] |=> mode_o == 2'b00);

    assert_vco_ref_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        vco_ref_o == (mode_o == 2'b11));

    assert_cmp_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'b00 || mode_o == 2'b01) |-> cmp_sel_o == 2'b00);

    assert_one_drive_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_o != 2'b00 |-> (son_o && (pdrv_oe_o != sdrv_oe_o)));
endmodule

bind spin_servo_seq spin_servo_seq_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cmd_i       (cmd_i),
    .samp_tick_i (samp_tick_i),
    .lock_i      (lock_i),
    .mode_o      (mode_o),
    .cmp_sel_o   (cmp_sel_o),
    .vco_ref_o   (vco_ref_o),
    .pdrv_o      (pdrv_o),
    .pdrv_oe_o   (pdrv_oe_o),
    .sdrv_oe_o   (sdrv_oe_o),
    .fdrv_o      (fdrv_o),
    .son_o       (son_o)
);

// File: tb/test_spin_servo_seq.sv
`timescale 1ns/1ps
module test_spin_servo_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cmd = 2'b10;
    logic       ref_sel = 1'b0, tick = 1'b0, lock = 1'b0, ph_err = 1'b0, spd_err = 1'b0;
    logic [1:0] mode, cmp_sel;
    logic       vco_ref, pdrv, pdrv_oe, sdrv, sdrv_oe, fdrv, son;
    int         total = 0, bad = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    spin_servo_seq i_spin_servo_seq (
        .clk_i(clk), .rst_i(rst), .cmd_i(cmd), .ref_sel_i(ref_sel),
        .samp_tick_i(tick), .lock_i(lock), .ph_err_i(ph_err), .spd_err_i(spd_err),
        .mode_o(mode), .cmp_sel_o(cmp_sel), .vco_ref_o(vco_ref),
        .pdrv_o(pdrv), .pdrv_oe_o(pdrv_oe), .sdrv_o(sdrv), .sdrv_oe_o(sdrv_oe),
        .fdrv_o(fdrv), .son_o(son)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic samp(logic lk);
        tick = 1'b1; lock = lk;
        step();
        tick = 1'b0; lock = 1'b0;
    endtask

    task automatic stop_pins(string tag);
        chk({tag, " son"},     son, 0);
        chk({tag, " fdrv"},    fdrv, 0);
        chk({tag, " pdrv"},    pdrv, 0);
        chk({tag, " pdrv_oe"}, pdrv_oe, 1);
        chk({tag, " sdrv_oe"}, sdrv_oe, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; cmd = 2'b00; step(2);
        chk("R1 mode after reset", mode, 0);
        stop_pins("R2 reset");
        rst = 1'b0;
    endtask

    task automatic t_start();
        cmd = 2'b00; step();
        chk("R3 stop->speed", mode, 1);
        spd_err = 1'b1; #1;
        chk("R10 speed sdrv_oe", sdrv_oe, 1);
        chk("R10 speed sdrv",    sdrv, 1);
        chk("R10 speed pdrv_oe", pdrv_oe, 0);
        chk("R10 speed son",     son, 1);
        chk("R9 speed cmp",      cmp_sel, 0);
        chk("R8 speed vco",      vco_ref, 0);
        spd_err = 1'b0;
    endtask

    task automatic t_lock_entry();
        lock = 1'b1; step(3); lock = 1'b0;
        chk("R4 lock w/o tick", mode, 1);
        samp(1'b0);
        chk("R4 unlocked tick in speed", mode, 1);
        samp(1'b1);
        chk("R4 speed->phase", mode, 2);
        ph_err = 1'b1; #1;
        chk("R10 phase pdrv",    pdrv, 1);
        chk("R10 phase pdrv_oe", pdrv_oe, 1);
        chk("R10 phase sdrv_oe", sdrv_oe, 0);
        chk("R10 phase fdrv",    fdrv, 1);
        ph_err = 1'b0;
    endtask

    task automatic t_unlock_run();
        for (int i = 0; i < 7; i++) begin samp(1'b0); step(); end
        chk("R5 after 7 unlocked", mode, 2);
        samp(1'b1);
        chk("R6 lock tick keeps phase", mode, 2);
        for (int i = 0; i < 7; i++) samp(1'b0);
        chk("R6 count restarted", mode, 2);
        samp(1'b0);
        chk("R5 8th unlocked -> speed", mode, 1);
    endtask

    task automatic t_stop_clear();
        samp(1'b1);
        chk("R4 relock", mode, 2);
        for (int i = 0; i < 5; i++) samp(1'b0);
        cmd = 2'b10; step();
        chk("R7 phase->stop", mode, 0);
        stop_pins("R2 stop cmd");
        cmd = 2'b00; step();
        chk("R3 restart speed", mode, 1);
        samp(1'b1);
        for (int i = 0; i < 7; i++) samp(1'b0);
        chk("R3 count cleared on restart", mode, 2);
        samp(1'b0);
        chk("R5 8th after restart", mode, 1);
    endtask

    task automatic t_rough();
        cmd = 2'b01; step();
        chk("R8 speed->rough", mode, 3);
        chk("R8 vco_ref", vco_ref, 1);
        ref_sel = 1'b0; #1;
        chk("R9 rough frame pair", cmp_sel, 1);
        ref_sel = 1'b1; #1;
        chk("R9 rough rw pair", cmp_sel, 2);
        samp(1'b1);
        chk("R8 tick ignored", mode, 3);
        cmd = 2'b00; step();
        chk("R8 rough->speed", mode, 1);
        samp(1'b1);
        chk("R9 phase rw pair", cmp_sel, 2);
        ref_sel = 1'b0; #1;
        chk("R9 phase frame pair", cmp_sel, 1);
        cmd = 2'b11; step();
        chk("R7 reserved stop", mode, 0);
        chk("R9 stop cmp", cmp_sel, 0);
        cmd = 2'b01; step();
        chk("R8 stop->rough", mode, 3);
        cmd = 2'b10; step();
        chk("R7 rough->stop", mode, 0);
    endtask

    initial begin
        step();
        t_reset();
        t_start();
        t_lock_entry();
        t_unlock_run();
        t_stop_clear();
        t_rough();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule